// File: doc/BRIEF.md
# Synthesizer Main Feedback Divider with Mode-Dependent Offset

This block is the programmable feedback divider of an integer-N frequency synthesizer. It divides the VCO-rate clock by a ratio taken from a 12-bit channel word. Each ratio step is one 0.512 MHz comparison period. The effective ratio gains two extra steps (1.024 MHz) in one of the two radio modes. A shift bit picks which mode: with the bit clear, receive gets the offset and transmit does not. With the bit set, transmit gets it and receive does not.

Every divide cycle produces one single-clock pulse. That pulse feeds the phase detector and any test observation path. A ratio change never cuts a cycle short, because the new count is loaded only when the running count ends. The channel word must be valid before the enable rises for the first time.

A companion reference divider runs in its own clock domain. It brings a 6.144 MHz or 12.288 MHz reference down to the same 0.512 MHz comparison rate, so both reference choices give the same channel step.

Top module: `pll_main_div`

## Requirements
- R1: While rst_ni is low, fb_o and ref_o are 0.
- R2: While en_i is low, fb_o stays 0. The counter is preloaded, and no pulse appears for as long as the enable stays low.
- R3: With shift_i = 0 and rx_i = 1 (receive), consecutive fb_o pulses are chan_i + 2 clock cycles apart.
- R4: With shift_i = 0 and rx_i = 0 (transmit), consecutive fb_o pulses are chan_i clock cycles apart.
- R5: With shift_i = 1, the offset moves to the other mode: transmit gives chan_i + 2 cycles and receive gives chan_i cycles.
- R6: fb_o is high for exactly one clock per divide cycle. After en_i goes high, with the enable previously low for at least one edge, the first pulse appears on the N-th rising edge, where N is the effective ratio.
- R7: A change of chan_i, rx_i or shift_i during a divide cycle leaves that cycle's length unchanged. The new ratio applies from the cycle that starts with the next pulse.
- R8: An effective ratio below 2 is raised to 2.
- R9: ref_o pulses once every 12 ref_clk_i cycles when ref_sel_i = 0, and once every 24 when ref_sel_i = 1. The reference divider runs while en_i, passed through two ref_clk_i flops, is high.
- R10: The full-scale word 0xFFF with the offset applied gives a period of 4097 cycles, with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | VCO-rate clock to be divided |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Divider enable |
| chan_i | input | 12 | Channel word, in 0.512 MHz steps |
| rx_i | input | 1 | Mode: 1 = receive, 0 = transmit |
| shift_i | input | 1 | Selects which mode receives the two-step offset |
| fb_o | output | 1 | Divided pulse, one clock wide |
| ref_clk_i | input | 1 | Reference oscillator clock |
| ref_sel_i | input | 1 | Reference divide select: 0 = divide by 12, 1 = divide by 24 |
| ref_o | output | 1 | Divided reference pulse, one ref_clk_i wide |

## Verification
The assertions check several properties on every cycle. Pulses on both outputs are one clock wide, and fb_o stays silent while the enable is low. No two pulses come closer than the minimum ratio. When the enable has stayed high through a whole cycle, its length equals the ratio taken from the inputs at the reload that started it. The bench scenarios show what the assertions cannot: the first-pulse latency after enabling, the exact period for each combination of mode and shift bit, and the deferred effect of a mid-cycle channel change. They also cover the clamp at small words, the full-scale count, and both reference divide settings with their synchronised enable.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;

  typedef enum logic {
    MODE_TX = 1'b0,
    MODE_RX = 1'b1
  } trx_mode_e;

  // offset goes to receive when shift is clear, to transmit when set
  function automatic logic offset_due(trx_mode_e mode, logic shift);
    return (mode == MODE_RX) ^ shift;
  endfunction

endpackage

// File: rtl/pll_ratio_sel.sv
module pll_ratio_sel
  import pll_div_pkg::*;
#(
  parameter int CHAN_W  = 12,
  parameter int CNT_W   = 13,
  parameter int OFFSET  = 2,
  parameter int MIN_DIV = 2
) (
  input  logic [CHAN_W-1:0] chan_i,
  input  logic              rx_i,
  input  logic              shift_i,
  output logic [CNT_W-1:0]  load_o
);

  trx_mode_e        mode;
  logic [CNT_W-1:0] sum_raw;
  logic [CNT_W-1:0] sum_clamp;

  assign mode = trx_mode_e'(rx_i);

  always_comb begin
    sum_raw = CNT_W'(chan_i);
    if (offset_due(mode, shift_i)) sum_raw = sum_raw + CNT_W'(OFFSET);
  end

  assign sum_clamp = (sum_raw < CNT_W'(MIN_DIV)) ? CNT_W'(MIN_DIV) : sum_raw;
  // counter runs load..0 inclusive
  assign load_o    = sum_clamp - CNT_W'(1);

endmodule

// File: rtl/pll_div_cnt.sv
module pll_div_cnt #(
  parameter int W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] load_i,
  output logic         pulse_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q   <= load_i;
      pulse_o <= 1'b0;
    end else if (cnt_q == '0) begin
      // terminal count: only point where a new ratio is taken
      cnt_q   <= load_i;
      pulse_o <= 1'b1;
    end else begin
      cnt_q   <= cnt_q - W'(1);
      pulse_o <= 1'b0;
    end
  end

endmodule

// File: rtl/pll_ref_div.sv
module pll_ref_div #(
  parameter int DIV_LO = 12,
  parameter int DIV_HI = 24
) (
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sel_i,
  output logic pulse_o
);

  localparam int W = $clog2(DIV_HI);

  logic         en_s1_q;
  logic         en_s2_q;
  logic [W-1:0] load;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_s1_q <= 1'b0;
      en_s2_q <= 1'b0;
    end else begin
      en_s1_q <= en_i;
      en_s2_q <= en_s1_q;
    end
  end

  assign load = sel_i ? W'(DIV_HI - 1) : W'(DIV_LO - 1);

  pll_div_cnt #(
    .W(W)
  ) u_cnt (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_s2_q),
    .load_i (load),
    .pulse_o(pulse_o)
  );

endmodule

// File: rtl/pll_main_div.sv
module pll_main_div #(
  parameter int CHAN_W     = 12,
  parameter int OFFSET     = 2,
  parameter int MIN_DIV    = 2,
  parameter int REF_DIV_LO = 12,
  parameter int REF_DIV_HI = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic              rx_i,
  input  logic              shift_i,
  output logic              fb_o,
  input  logic              ref_clk_i,
  input  logic              ref_sel_i,
  output logic              ref_o
);

  localparam int CNT_W = $clog2((1 << CHAN_W) + OFFSET);

  logic [CNT_W-1:0] load;

  pll_ratio_sel #(
    .CHAN_W (CHAN_W),
    .CNT_W  (CNT_W),
    .OFFSET (OFFSET),
    .MIN_DIV(MIN_DIV)
  ) u_ratio (
    .chan_i (chan_i),
    .rx_i   (rx_i),
    .shift_i(shift_i),
    .load_o (load)
  );

  pll_div_cnt #(
    .W(CNT_W)
  ) u_main_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_i),
    .load_i (load),
    .pulse_o(fb_o)
  );

  pll_ref_div #(
    .DIV_LO(REF_DIV_LO),
    .DIV_HI(REF_DIV_HI)
  ) u_ref_div (
    .ref_clk_i(ref_clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .sel_i    (ref_sel_i),
    .pulse_o  (ref_o)
  );

endmodule

// File: rtl/pll_main_div_chk.sv
module pll_main_div_chk #(
  parameter int CHAN_W     = 12,
  parameter int OFFSET     = 2,
  parameter int MIN_DIV    = 2,
  parameter int REF_DIV_LO = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [CHAN_W-1:0] chan_i,
  input logic              rx_i,
  input logic              shift_i,
  input logic              fb_o,
  input logic              ref_clk_i,
  input logic              ref_o
);

  localparam int GW = CHAN_W + 2;

  logic [GW-1:0] exp_n;
  logic [GW-1:0] exp_q;
  logic [GW-1:0] per_snap_q;
  logic [GW-1:0] gap_q;
  logic          seen_q;
  logic          run_ok_q;
  logic [7:0]    ref_gap_q;
  logic          ref_seen_q;

  always_comb begin
    exp_n = GW'(chan_i) + ((rx_i != shift_i) ? GW'(OFFSET) : GW'(0));
    if (exp_n < GW'(MIN_DIV)) exp_n = GW'(MIN_DIV);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q      <= '0;
      per_snap_q <= '0;
      gap_q      <= '0;
      seen_q     <= 1'b0;
      run_ok_q   <= 1'b0;
    end else begin
      exp_q <= exp_n;
      if (fb_o) begin
        per_snap_q <= exp_q;
        gap_q      <= '0;
        seen_q     <= 1'b1;
        run_ok_q   <= en_i;
      end else begin
        if (gap_q != '1) gap_q <= gap_q + GW'(1);
        run_ok_q <= run_ok_q & en_i;
      end
    end
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_gap_q  <= '0;
      ref_seen_q <= 1'b0;
    end else if (ref_o) begin
      ref_gap_q  <= '0;
      ref_seen_q <= 1'b1;
    end else if (ref_gap_q != '1) begin
      ref_gap_q <= ref_gap_q + 8'd1;
    end
  end

  AST_FB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_o |=> !fb_o); // R6
  AST_FB_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !fb_o); // R2
  AST_FB_MIN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_o && seen_q) |-> (gap_q >= GW'(MIN_DIV - 1))); // R8
  AST_FB_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_o && seen_q && run_ok_q) |-> (gap_q == per_snap_q - GW'(1))); // R7
  AST_REF_SINGLE: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    ref_o |=> !ref_o); // R9
  AST_REF_MIN_GAP: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (ref_o && ref_seen_q) |-> (ref_gap_q >= 8'(REF_DIV_LO - 1))); // R9

endmodule

bind pll_main_div pll_main_div_chk #(
  .CHAN_W    (CHAN_W),
  .OFFSET    (OFFSET),
  .MIN_DIV   (MIN_DIV),
  .REF_DIV_LO(REF_DIV_LO)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .chan_i   (chan_i),
  .rx_i     (rx_i),
  .shift_i  (shift_i),
  .fb_o     (fb_o),
  .ref_clk_i(ref_clk_i),
  .ref_o    (ref_o)
);

// File: tb/pll_main_div_tb.sv
`timescale 1ns/1ps
module pll_main_div_tb;

  logic        clk = 1'b0;
  logic        ref_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        rx = 1'b0;
  logic        shift = 1'b0;
  logic        ref_sel = 1'b0;
  logic [11:0] chan = '0;
  logic        fb;
  logic        refp;

  int    n_checks = 0;
  int    n_err = 0;
  string tag = "R1";
  bit    done = 1'b0;

  always #2.5 clk = ~clk;
  always #4 ref_clk = ~ref_clk;

  pll_main_div u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .en_i     (en),
    .chan_i   (chan),
    .rx_i     (rx),
    .shift_i  (shift),
    .fb_o     (fb),
    .ref_clk_i(ref_clk),
    .ref_sel_i(ref_sel),
    .ref_o    (refp)
  );

  function automatic void chk(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endfunction

  // period from the requirements: word + 2 when mode and shift disagree, floor 2
  function automatic int eff(logic [11:0] c, logic r, logic s);
    int v;
    v = int'(c) + ((r != s) ? 2 : 0);
    if (v < 2) v = 2;
    return v;
  endfunction

  // behavioural model: edges left until the next pulse
  int   m_left;
  logic m_fb;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_left = 0;
      m_fb   = 1'b0;
    end else if (!en) begin
      m_fb   = 1'b0;
      m_left = eff(chan, rx, shift);
    end else begin
      m_left = m_left - 1;
      if (m_left <= 0) begin
        m_fb   = 1'b1;
        m_left = eff(chan, rx, shift);
      end else begin
        m_fb = 1'b0;
      end
    end
  end

  int   r_left;
  logic r_fb;
  logic r_s1, r_s2, r_run;
  always @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      r_left = 0;
      r_fb   = 1'b0;
      r_s1   = 1'b0;
      r_s2   = 1'b0;
    end else begin
      r_run = r_s2;
      r_s2  = r_s1;
      r_s1  = en;
      if (!r_run) begin
        r_fb   = 1'b0;
        r_left = ref_sel ? 24 : 12;
      end else begin
        r_left = r_left - 1;
        if (r_left <= 0) begin
          r_fb   = 1'b1;
          r_left = ref_sel ? 24 : 12;
        end else begin
          r_fb = 1'b0;
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) chk(fb === m_fb, tag, int'(fb), int'(m_fb));
  always @(negedge ref_clk) if (rst_n && !done) chk(refp === r_fb, "R9", int'(refp), int'(r_fb));

  task automatic wait_fb();
    do @(negedge clk); while (fb !== 1'b1);
  endtask

  task automatic gap_fb(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (fb !== 1'b1);
  endtask

  task automatic period_fb(input int exp, input string req);
    int n;
    wait_fb();
    gap_fb(n);
    chk(n == exp, req, n, exp);
  endtask

  task automatic period_ref(input int exp);
    int n;
    do @(negedge ref_clk); while (refp !== 1'b1);
    n = 0;
    do begin
      @(negedge ref_clk);
      n++;
    end while (refp !== 1'b1);
    chk(n == exp, "R9", n, exp);
  endtask

  function automatic void summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
  endfunction

  initial begin
    #900000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    int cnt;
    repeat (3) @(negedge clk);
    chk(fb === 1'b0, "R1", int'(fb), 0);
    chk(refp === 1'b0, "R1", int'(refp), 0);
    rst_n = 1'b1;

    tag  = "R2";
    chan = 12'd10;
    cnt  = 0;
    repeat (20) begin
      @(negedge clk);
      if (fb) cnt++;
    end
    chk(cnt == 0, "R2", cnt, 0);

    tag = "R6";
    en  = 1'b1;
    gap_fb(n);
    chk(n == 10, "R6", n, 10);
    @(negedge clk);
    chk(fb === 1'b0, "R6", int'(fb), 0);

    tag  = "R4";
    chan = 12'd37;
    period_fb(37, "R4");
    chan = 12'h400;
    period_fb(1024, "R4");

    tag  = "R3";
    rx   = 1'b1;
    chan = 12'd37;
    period_fb(39, "R3");

    tag   = "R5";
    shift = 1'b1;
    period_fb(37, "R5");
    rx = 1'b0;
    period_fb(39, "R5");

    tag   = "R7";
    shift = 1'b0;
    chan  = 12'd20;
    period_fb(20, "R7");
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 3) chan = 12'd8;
    end while (fb !== 1'b1);
    chk(n == 20, "R7", n, 20);
    gap_fb(n);
    chk(n == 8, "R7", n, 8);

    tag  = "R8";
    chan = 12'd0;
    period_fb(2, "R8");
    chan = 12'd1;
    period_fb(2, "R8");
    rx   = 1'b1;
    chan = 12'd0;
    period_fb(2, "R8");

    tag  = "R10";
    chan = 12'hFFF;
    period_fb(4097, "R10");

    tag = "R9";
    period_ref(12);
    ref_sel = 1'b1;
    period_ref(24);
    period_ref(24);

    tag = "R2";
    en  = 1'b0;
    @(negedge clk);
    cnt = 0;
    repeat (30) begin
      @(negedge clk);
      if (fb) cnt++;
    end
    chk(cnt == 0, "R2", cnt, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule